// File: doc/BRIEF.md
# Multiplexed External Bus Controller

This block is the master side of an external bus on which address and data share one set of 32 AD lines. An internal requester presents an address, a direction, an access size (byte, halfword or word) and, for writes, the data. The controller compares the address with a set of chip-select windows. Each window has a base, a mask, a port width and a wait-state count. The access then runs as one or more bus cycles. Each cycle has a single address clock, marked by an address-latch strobe, followed by a data phase during which the window's chip select is held low.

When the access is wider than the window's port, it is split into consecutive complete cycles. Each of these cycles has its own latch strobe and its own chip-select pulse. The most significant part of the data travels first, and the address advances by the port width on each cycle. Narrow data always sits on the top byte lanes. Lanes that carry no data keep the address value they held in the address clock. Read data is gathered from the same lanes and returned right-justified. The requester receives one done pulse, and only after the final cycle.

Top module: `mbus_ctrl`

## Requirements
- R1: Window n matches when `(addr[31:16] & ~mask_n[31:16]) == base_n[31:16]` and `mask_n[0]` is 1. Bits [15:0] of the base take no part in the decode. When several windows match, the lowest index wins.
- R2: A window whose `mask_n[0]` is 0 never asserts its chip select. A request that matches no usable window produces a done pulse on the clock after acceptance, with no latch strobe and no chip select.
- R3: Each bus cycle starts with exactly one clock in which `bus_ale` is 1, `bus_ad_oe` is 1, `bus_ad_out` carries the cycle's address, and every chip select is high.
- R4: With internal termination, the selected active-low chip select stays low for exactly 1 + wait clocks after each address clock. The wait count is the window's `cfg_wait` field.
- R5: Port width encoding is 0 = 8-bit, 1 = 16-bit, 2 or 3 = 32-bit. Size encoding is 0 = byte, 1 = halfword, 2 or 3 = word. An access of B bytes to a port of P bytes, with B > P, runs B/P complete cycles. Chip select is high during each intervening address clock.
- R6: Split cycles follow big-endian order. The first cycle carries the most significant part of the data, and each later cycle's address is the previous one plus the number of bytes moved per cycle.
- R7: During a write data phase, data occupies the top lanes: AD[31:24] for 8 bits moved, AD[31:16] for 16 bits, all 32 for 32 bits. The remaining lanes keep the address value from that cycle's address clock.
- R8: `bus_rw_n` is 0 throughout every write cycle and 1 otherwise. In a read data phase `bus_ad_oe` is 0.
- R9: On reads, the top lanes of `bus_ad_in` are sampled on the last data clock of each cycle. The pieces are assembled most significant first and returned right-justified on `req_rdata` while `req_done` is 1.
- R10: `req_done` is a single-clock pulse on the clock after the last data clock. A new request is accepted only while idle and while `req_done` is 0.
- R11: After reset, all chip selects are high, `bus_ale` is 0, `bus_rw_n` is 1 and `req_done` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present; held until `req_done` |
| req_addr | input | 32 | Byte address of the access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| req_wdata | input | 32 | Write data, right-justified |
| req_done | output | 1 | One-clock completion pulse |
| req_rdata | output | 32 | Read data, right-justified, valid with `req_done` |
| cfg_base | input | NUM_CS*32 | Window bases, window n in bits [32n+31:32n] |
| cfg_mask | input | NUM_CS*32 | Window masks; bit 0 of each is the valid bit |
| cfg_wait | input | NUM_CS*WAIT_W | Wait states per window |
| cfg_pw | input | NUM_CS*2 | Port width code per window |
| bus_ad_out | output | 32 | Driven AD value |
| bus_ad_oe | output | 1 | AD output enable |
| bus_ad_in | input | 32 | Sampled AD value for reads |
| bus_ale | output | 1 | Address latch strobe, high for the address clock |
| bus_rw_n | output | 1 | Low for write cycles |
| bus_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The request is accepted on the first edge after it is raised. The address clock of the first cycle is visible right after that edge, and the data clocks follow one per edge, 1 + wait of them. The next address clock, or the done pulse, appears on the edge after the last data clock. A miss raises done on the very edge that accepted it. The bench derives this timeline for every access from the window settings it programmed. It samples at each falling edge in that exact sequence, so a strobe, chip-select or done that comes one clock early or late fails the matching clock's comparison.

// File: rtl/mbc_pkg.sv
package mbc_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ADDR = 2'd1,
        PH_DATA = 2'd2
    } phase_e;

    typedef struct packed {
        logic [31:0] addr;    // address of the current cycle
        logic [31:0] shift;   // write data, left-justified, next piece on top
        logic [31:0] acc;     // read data gathered so far
        logic        write;
        logic [2:0]  tw;      // bytes moved per cycle
        logic [2:0]  beats;   // cycles still to run, including the current one
    } xfer_t;

    function automatic logic [2:0] code_bytes(input logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    function automatic logic [31:0] top_lanes(input logic [2:0] tw);
        case (tw)
            3'd1:    return 32'hFF00_0000;
            3'd2:    return 32'hFFFF_0000;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    function automatic logic [31:0] left_justify(input logic [31:0] d, input logic [2:0] nbytes);
        case (nbytes)
            3'd1:    return {d[7:0], 24'h0};
            3'd2:    return {d[15:0], 16'h0};
            default: return d;
        endcase
    endfunction

    function automatic logic [31:0] advance(input logic [31:0] d, input logic [2:0] tw);
        case (tw)
            3'd1:    return {d[23:0], 8'h0};
            3'd2:    return {d[15:0], 16'h0};
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/mbc_decode.sv
module mbc_decode #(
    parameter int NUM_CS = 4,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [31:0]          addr,
    input  logic [NUM_CS*32-1:0] base,
    input  logic [NUM_CS*32-1:0] mask,
    output logic                 hit,
    output logic [SEL_W-1:0]     sel
);
    logic [NUM_CS-1:0] match;
    logic              unused_low_bits;

    genvar g;
    generate
        for (g = 0; g < NUM_CS; g++) begin : g_win
            assign match[g] = mask[g*32] &&
                ((addr[31:16] & ~mask[g*32+16 +: 16]) == base[g*32+16 +: 16]);
        end
    endgenerate

    // lowest index has priority
    always_comb begin
        hit = 1'b0;
        sel = '0;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                sel = SEL_W'(i);
            end
        end
    end

    assign unused_low_bits = ^{base, mask, addr[15:0]};

endmodule

// File: rtl/mbc_lanes.sv
module mbc_lanes
    import mbc_pkg::*;
(
    input  phase_e      phase,
    input  logic        write,
    input  logic [2:0]  tw,
    input  logic [31:0] addr,
    input  logic [31:0] shift,
    input  logic [31:0] acc,
    input  logic [31:0] ad_in,
    output logic [31:0] ad_out,
    output logic        ad_oe,
    output logic [31:0] acc_next
);
    logic [31:0] lanes;

    assign lanes = top_lanes(tw);

    always_comb begin
        case (phase)
            PH_ADDR: begin
                ad_out = addr;
                ad_oe  = 1'b1;
            end
            PH_DATA: begin
                ad_out = write ? ((shift & lanes) | (addr & ~lanes)) : addr;
                ad_oe  = write;
            end
            default: begin
                ad_out = 32'h0;
                ad_oe  = 1'b0;
            end
        endcase
    end

    always_comb begin
        case (tw)
            3'd1:    acc_next = {acc[23:0], ad_in[31:24]};
            3'd2:    acc_next = {acc[15:0], ad_in[31:16]};
            default: acc_next = ad_in;
        endcase
    end

endmodule

// File: rtl/mbus_ctrl.sv
module mbus_ctrl
    import mbc_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int WAIT_W = 4,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    input  logic [31:0]              req_addr,
    input  logic                     req_write,
    input  logic [1:0]               req_size,
    input  logic [31:0]              req_wdata,
    output logic                     req_done,
    output logic [31:0]              req_rdata,
    input  logic [NUM_CS*32-1:0]     cfg_base,
    input  logic [NUM_CS*32-1:0]     cfg_mask,
    input  logic [NUM_CS*WAIT_W-1:0] cfg_wait,
    input  logic [NUM_CS*2-1:0]      cfg_pw,
    output logic [31:0]              bus_ad_out,
    output logic                     bus_ad_oe,
    input  logic [31:0]              bus_ad_in,
    output logic                     bus_ale,
    output logic                     bus_rw_n,
    output logic [NUM_CS-1:0]        bus_cs_n
);
    phase_e            phase;
    xfer_t             x;
    logic [SEL_W-1:0]  sel_q;
    logic [WAIT_W-1:0] wcnt;
    logic [WAIT_W-1:0] wlim;
    logic              done_q;

    logic              dec_hit;
    logic [SEL_W-1:0]  dec_sel;
    logic [2:0]        req_bytes;
    logic [2:0]        port_bytes;
    logic [2:0]        tw_n;
    logic [2:0]        beats_n;
    logic [31:0]       acc_next;
    logic              accept;

    mbc_decode #(.NUM_CS(NUM_CS)) u_decode (
        .addr (req_addr),
        .base (cfg_base),
        .mask (cfg_mask),
        .hit  (dec_hit),
        .sel  (dec_sel)
    );

    mbc_lanes u_lanes (
        .phase    (phase),
        .write    (x.write),
        .tw       (x.tw),
        .addr     (x.addr),
        .shift    (x.shift),
        .acc      (x.acc),
        .ad_in    (bus_ad_in),
        .ad_out   (bus_ad_out),
        .ad_oe    (bus_ad_oe),
        .acc_next (acc_next)
    );

    // split planning for the incoming request
    always_comb begin
        req_bytes  = code_bytes(req_size);
        port_bytes = code_bytes(cfg_pw[int'(dec_sel)*2 +: 2]);
        tw_n       = (req_bytes <= port_bytes) ? req_bytes : port_bytes;
        if (req_bytes <= port_bytes)
            beats_n = 3'd1;
        else if (req_bytes == 3'd4 && port_bytes == 3'd1)
            beats_n = 3'd4;
        else
            beats_n = 3'd2;
    end

    assign accept = (phase == PH_IDLE) && req_valid && !done_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            x      <= '0;
            sel_q  <= '0;
            wcnt   <= '0;
            wlim   <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (accept) begin
                        x.addr  <= req_addr;
                        x.write <= req_write;
                        x.tw    <= tw_n;
                        x.beats <= beats_n;
                        x.shift <= left_justify(req_wdata, req_bytes);
                        x.acc   <= 32'h0;
                        sel_q   <= dec_sel;
                        wlim    <= cfg_wait[int'(dec_sel)*WAIT_W +: WAIT_W];
                        if (dec_hit) phase  <= PH_ADDR;
                        else         done_q <= 1'b1;
                    end
                end
                PH_ADDR: begin
                    phase <= PH_DATA;
                    wcnt  <= '0;
                end
                PH_DATA: begin
                    if (wcnt == wlim) begin
                        if (!x.write) x.acc <= acc_next;
                        if (x.beats == 3'd1) begin
                            phase  <= PH_IDLE;
                            done_q <= 1'b1;
                        end else begin
                            phase   <= PH_ADDR;
                            x.beats <= x.beats - 3'd1;
                            x.addr  <= x.addr + {29'h0, x.tw};
                            x.shift <= advance(x.shift, x.tw);
                        end
                    end else begin
                        wcnt <= wcnt + 1'b1;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign req_done  = done_q;
    assign req_rdata = x.acc;
    assign bus_ale   = (phase == PH_ADDR);
    assign bus_rw_n  = !((phase != PH_IDLE) && x.write);
    assign bus_cs_n  = (phase == PH_DATA) ? ~(NUM_CS'(1) << sel_q) : '1;

    // at most one chip select low at a time
    p_cs_onehot_r5: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    // latch strobe lasts a single clock
    p_ale_single_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !bus_ale);

    // no chip select during the address clock
    p_ale_no_cs_r3: assert property (@(posedge clk) disable iff (rst)
        bus_ale |-> (&bus_cs_n));

    // data phase with chip select follows every address clock
    p_cs_after_ale_r4: assert property (@(posedge clk) disable iff (rst)
        bus_ale |=> !(&bus_cs_n));

    // direction does not change inside a data phase
    p_rw_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !(&bus_cs_n) |-> $stable(bus_rw_n));

    // completion only with the bus quiet
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        req_done |-> ((&bus_cs_n) && !bus_ale));

    // done is a single pulse
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        (req_done && !$past(req_done)) |=> !req_done);

endmodule

// File: tb/tb_mbus_ctrl.sv
`timescale 1ns/1ps
module tb_mbus_ctrl;
    localparam int NCS = 4;
    localparam int WW  = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [31:0]       req_addr = '0;
    logic              req_write = 1'b0;
    logic [1:0]        req_size = '0;
    logic [31:0]       req_wdata = '0;
    logic              req_done;
    logic [31:0]       req_rdata;
    logic [NCS*32-1:0] cfg_base;
    logic [NCS*32-1:0] cfg_mask;
    logic [NCS*WW-1:0] cfg_wait;
    logic [NCS*2-1:0]  cfg_pw;
    logic [31:0]       bus_ad_out;
    logic              bus_ad_oe;
    logic [31:0]       bus_ad_in = '0;
    logic              bus_ale;
    logic              bus_rw_n;
    logic [NCS-1:0]    bus_cs_n;

    int checks = 0;
    int errors = 0;

    // window settings used both by the DUT and the bench model
    logic [31:0] m_base [NCS] = '{32'h0400_0000, 32'h2000_ABCD, 32'h3000_0000, 32'h5000_0000};
    logic [31:0] m_mask [NCS] = '{32'h0000_0001, 32'h00FF_0001, 32'h0000_0000, 32'h0000_0001};
    int          m_wait [NCS] = '{4, 1, 2, 0};
    int          m_pw   [NCS] = '{0, 1, 0, 2};

    always #2.5 clk = ~clk;

    mbus_ctrl #(.NUM_CS(NCS), .WAIT_W(WW)) dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
        .req_size(req_size), .req_wdata(req_wdata),
        .req_done(req_done), .req_rdata(req_rdata),
        .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_wait(cfg_wait), .cfg_pw(cfg_pw),
        .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe), .bus_ad_in(bus_ad_in),
        .bus_ale(bus_ale), .bus_rw_n(bus_rw_n), .bus_cs_n(bus_cs_n)
    );

    always_comb begin
        for (int i = 0; i < NCS; i++) begin
            cfg_base[i*32 +: 32] = m_base[i];
            cfg_mask[i*32 +: 32] = m_mask[i];
            cfg_wait[i*WW +: WW] = WW'(m_wait[i]);
            cfg_pw[i*2 +: 2]     = 2'(m_pw[i]);
        end
    end

    task automatic chk(input string tag, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    function automatic int nbytes(input int code);
        return (code == 0) ? 1 : (code == 1) ? 2 : 4;
    endfunction

    // reference access model: walks the expected bus timeline clock by clock
    task automatic access(input string tag, input logic [31:0] addr, input bit wr,
                          input int size, input logic [31:0] data);
        int     sel = -1;
        int     bytes, pb, tw, beats;
        longint lowm, val, expad;
        for (int i = NCS - 1; i >= 0; i--)
            if (m_mask[i][0] && ((addr[31:16] & ~m_mask[i][31:16]) == m_base[i][31:16]))
                sel = i;
        @(negedge clk);
        req_addr  = addr;
        req_write = wr;
        req_size  = 2'(size);
        req_wdata = wr ? data : 32'hDEAD_BEEF;
        req_valid = 1'b1;
        if (sel < 0) begin
            @(negedge clk);
            chk(tag, "miss done", {63'h0, req_done}, 64'h1);
            chk(tag, "miss cs_n", {60'h0, bus_cs_n}, 64'hF);
            chk(tag, "miss ale", {63'h0, bus_ale}, 64'h0);
            req_valid = 1'b0;
            @(negedge clk);
            chk(tag, "miss done drop", {63'h0, req_done}, 64'h0);
            return;
        end
        bytes = nbytes(size);
        pb    = nbytes(m_pw[sel]);
        tw    = (bytes < pb) ? bytes : pb;
        beats = bytes / tw;
        lowm  = (64'h1 << (32 - 8 * tw)) - 1;
        for (int b = 0; b < beats; b++) begin
            longint ab = longint'(addr) + b * tw;
            val   = (longint'(data) >> (8 * (bytes - tw * (b + 1)))) & ((64'h1 << (8 * tw)) - 1);
            expad = ((ab & lowm) | (val << (32 - 8 * tw))) & 64'hFFFF_FFFF;
            @(negedge clk);
            chk(tag, "addr clock ale", {63'h0, bus_ale}, 64'h1);
            chk(tag, "addr clock cs_n", {60'h0, bus_cs_n}, 64'hF);
            chk(tag, "addr clock ad", {32'h0, bus_ad_out}, ab & 64'hFFFF_FFFF);
            chk(tag, "addr clock oe", {63'h0, bus_ad_oe}, 64'h1);
            chk(tag, "addr clock rw_n", {63'h0, bus_rw_n}, {63'h0, !wr});
            chk(tag, "no early done", {63'h0, req_done}, 64'h0);
            if (!wr) bus_ad_in = 32'(expad ^ (64'h5A5A_5A5A & lowm));
            for (int w = 0; w <= m_wait[sel]; w++) begin
                @(negedge clk);
                chk(tag, "data clock ale", {63'h0, bus_ale}, 64'h0);
                chk(tag, "data clock cs_n", {60'h0, bus_cs_n}, {60'h0, ~(4'(1) << sel)});
                chk(tag, "data clock rw_n", {63'h0, bus_rw_n}, {63'h0, !wr});
                chk(tag, "data clock oe", {63'h0, bus_ad_oe}, {63'h0, wr});
                if (wr) chk(tag, "data clock ad", {32'h0, bus_ad_out}, expad);
            end
        end
        @(negedge clk);
        chk(tag, "done pulse", {63'h0, req_done}, 64'h1);
        chk(tag, "cs_n released", {60'h0, bus_cs_n}, 64'hF);
        if (!wr) chk(tag, "read data", {32'h0, req_rdata}, {32'h0, data});
        req_valid = 1'b0;
        @(negedge clk);
        chk(tag, "done single", {63'h0, req_done}, 64'h0);
        chk(tag, "idle rw_n", {63'h0, bus_rw_n}, 64'h1);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11: reset state
        chk("R11", "cs_n", {60'h0, bus_cs_n}, 64'hF);
        chk("R11", "ale", {63'h0, bus_ale}, 64'h0);
        chk("R11", "rw_n", {63'h0, bus_rw_n}, 64'h1);
        chk("R11", "done", {63'h0, req_done}, 64'h0);

        // R4 R7: byte write to 8-bit port, 4 waits
        access("R4", 32'h0400_0010, 1'b1, 0, 32'h0000_0044);
        // R5 R6: halfword split into two byte cycles
        access("R5", 32'h0400_0020, 1'b1, 1, 32'h0000_3F41);
        // R9 R6: word read over four byte cycles
        access("R9", 32'h0400_0100, 1'b0, 2, 32'h1122_3344);
        // R1 R7: window whose base low bits are nonzero, 16-bit port, word write
        access("R1", 32'h2012_3456, 1'b1, 2, 32'hCAFE_BEEF);
        // R9: byte read on 16-bit port
        access("R9", 32'h20FF_0001, 1'b0, 0, 32'h0000_009C);
        // R7: full word on 32-bit port, zero waits
        access("R7", 32'h5000_0100, 1'b1, 2, 32'h89AB_CDEF);
        // R7: halfword on 32-bit port keeps address in low lanes
        access("R7", 32'h5000_0202, 1'b1, 1, 32'h0000_7E81);
        // R8: halfword read on 32-bit port
        access("R8", 32'h5000_0300, 1'b0, 1, 32'h0000_A55A);
        // R2: window with valid bit clear
        access("R2", 32'h3000_0000, 1'b1, 0, 32'h0000_0011);
        // R1: just outside a 64 KiB window
        access("R1", 32'h0401_0000, 1'b0, 0, 32'h0000_0000);
        // R10: back-to-back accesses after done
        access("R10", 32'h0400_FFFE, 1'b1, 1, 32'h0000_1234);
        access("R10", 32'h2000_0000, 1'b0, 1, 32'h0000_4321);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule